// File: doc/BRIEF.md
# IR Run-Length Receive Sampler

This block turns the digital output of an infrared receiver into a stream of run-length coded bytes. The input passes through a synchronizer and an optional polarity inversion. It is then sampled at a fixed period, and the length of every pulse and every space is counted in sample periods. Each finished run becomes one byte, or several bytes for a long run. The bytes go into a small receive FIFO that the host drains through a read port. An interrupt level rises when the FIFO holds enough bytes. A sticky overrun flag reports that a byte was lost because the FIFO was full.

The sample period has two settings: a coarse one for normal reception and a fine one for carrier measurement. Alongside the sampler, a carrier edge counter counts rising edges of the conditioned input while it is enabled. Software divides that count by the total pulse time to estimate the carrier frequency.

The run-length state machine has four states:

- `RX_IDLE`: waits for the first pulse sample.
- `RX_PULSE`: measures a pulse run.
- `RX_SPACE`: measures a space run.
- `RX_ERROR`: entered on overrun; drops all bytes.

Its transitions are:

- Start: `RX_IDLE` to `RX_PULSE` on a sample that sees a pulse.
- Flip: `RX_PULSE` to `RX_SPACE`, or the reverse, on a sample whose level differs from the current run; the finished run is emitted.
- Split: stay in the same state when a run reaches 128 samples; a full-length byte is emitted and counting restarts.
- Overflow: `RX_PULSE` or `RX_SPACE` to `RX_ERROR` when a byte is emitted into a full FIFO that is not being read in the same cycle.
- Abort: any state to `RX_IDLE` while `rx_disable` is high.

Top module: `irrx_sampler`

## Requirements
- R1: Each byte encodes one run. Bit 7 is 1 for a space and 0 for a pulse, and bits 6:0 hold the number of samples in the run minus one. A pulse is a high level after the optional inversion. A run's byte is pushed on the first sample of the following run of the opposite level.
- R2: The sample period is `SLOW_DIV` clock cycles when `oversample` is low and `FAST_DIV` clock cycles when it is high.
- R3: A run longer than 128 samples is split. Each full 128 samples emits a byte with bits 6:0 = 127 (0x7F for a pulse, 0xFF for a space), and the remainder follows as a final byte of the same polarity. A run of exactly 128 samples gives the single byte 0x7F or 0xFF.
- R4: After reset or abort, the receiver stays idle and records nothing, however long the space lasts. The first sample that sees a pulse starts a new pulse run and counts as its first sample.
- R5: While `rx_disable` is high, the receiver returns to idle, pushes nothing, and discards the run in progress.
- R6: With `invert` high, the synchronized input is complemented before measurement, so an inverted waveform yields the same bytes.
- R7: The FIFO holds `DEPTH` (16) bytes in arrival order. `rd_data` shows the oldest byte, a high `rd_en` removes it, `data_avail` is high when the FIFO is not empty, and `fifo_level` gives the byte count.
- R8: `irq_rx` is high exactly while `fifo_level` is at least `IRQ_THRESH` (8).
- R9: A byte arriving while the FIFO is full and not being read is dropped and sets `overrun`. The receiver then drops every later byte until an abort, even after the FIFO has been drained.
- R10: A pulse on `stat_rd` clears `overrun`; a new overrun in the same cycle wins.
- R11: The `CNT_W`-bit carrier counter adds one for each rising edge of the conditioned input while `cnt_en` is high. It holds its value while `cnt_en` is low, and `cnt_clr` zeroes it with priority.
- R12: The carrier counter saturates at all ones. `carrier_valid` is high only when the count is neither zero nor all ones.
- R13: After reset the FIFO is empty, `overrun`, `irq_rx`, `carrier_count` and `carrier_valid` are zero, and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Raw receiver input, asynchronous |
| oversample | input | 1 | Selects the fine sample period |
| invert | input | 1 | Complements the synchronized input |
| rx_disable | input | 1 | Forces the receiver to idle |
| cnt_en | input | 1 | Carrier counter enable |
| cnt_clr | input | 1 | Carrier counter clear |
| rd_en | input | 1 | Removes the oldest FIFO byte |
| stat_rd | input | 1 | Status read strobe; clears overrun |
| rd_data | output | 8 | Oldest FIFO byte |
| data_avail | output | 1 | FIFO not empty |
| overrun | output | 1 | Sticky overrun flag |
| fifo_level | output | $clog2(DEPTH+1) | Bytes held in the FIFO |
| irq_rx | output | 1 | FIFO level at or above threshold |
| carrier_count | output | CNT_W | Carrier edge count |
| carrier_valid | output | 1 | Count is usable |

## Verification
A wrong run state or run counter shows up at the ports as a byte with the wrong value or polarity. It appears one sample period plus two synchronizer cycles after the next input level change, or after 128 samples of an unbroken run. Because the bench holds each level for an exact multiple of the sample period, every byte value is predictable regardless of the sampling phase. A missed error state shows as bytes reaching the FIFO after an overrun, visible in `fifo_level` as soon as the next run closes. A wrong carrier count is visible at `carrier_count` within three cycles of the last input edge.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
    localparam int RUN_W  = 7;
    localparam int BYTE_W = RUN_W + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_PULSE = 2'd1,
        RX_SPACE = 2'd2,
        RX_ERROR = 2'd3
    } rx_state_e;
endpackage

// File: rtl/irrx_cond.sv
module irrx_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_in,
    input  logic invert,
    output logic level,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_q;

    // shift the asynchronous input through the synchronizer chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            level_q <= 1'b0;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], ir_in};
            level_q <= level;
        end
    end

    assign level = sync_q[SYNC_STAGES-1] ^ invert;
    assign rise  = level & ~level_q;
endmodule

// File: rtl/irrx_tick.sv
module irrx_tick #(
    parameter int SLOW_DIV = 1000,
    parameter int FAST_DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic tick
);
    localparam int DIV_W = $clog2(SLOW_DIV + 1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    assign limit = fast ? DIV_W'(FAST_DIV - 1) : DIV_W'(SLOW_DIV - 1);
    assign tick  = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/irrx_runlen.sv
module irrx_runlen
    import irrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              level,
    input  logic              rx_disable,
    input  logic              fifo_full,
    input  logic              fifo_pop,
    output logic              push,
    output logic [BYTE_W-1:0] push_byte
);
    rx_state_e        state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic             in_run;
    logic             same_lvl;
    logic             run_close;
    logic             drop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // outputs: run closes on a level flip or at the maximum length
    always_comb begin
        in_run    = (state_q == RX_PULSE) || (state_q == RX_SPACE);
        same_lvl  = (level == (state_q == RX_PULSE));
        run_close = tick && in_run && !rx_disable &&
                    (!same_lvl || (run_q == RUN_MAX));
        push      = run_close;
        push_byte = {(state_q == RX_SPACE), run_q};
        drop      = run_close && fifo_full && !fifo_pop;
    end

    // next state
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (rx_disable) begin
            state_d = RX_IDLE;
            run_d   = '0;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    if (tick && level) begin
                        state_d = RX_PULSE;
                        run_d   = '0;
                    end
                end
                RX_PULSE, RX_SPACE: begin
                    if (tick) begin
                        if (run_close) run_d = '0;
                        else           run_d = run_q + RUN_W'(1);
                        if (!same_lvl) state_d = level ? RX_PULSE : RX_SPACE;
                        if (drop)      state_d = RX_ERROR;
                    end
                end
                RX_ERROR: state_d = RX_ERROR;
            endcase
        end
    end
endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    input  logic                         stat_rd,
    output logic [W-1:0]                 rd_data,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         overrun
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [LVL_W-1:0] level_q;
    logic             wr_ok, rd_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (level_q == LVL_W'(DEPTH));
    assign rd_ok   = pop && (level_q != '0);
    assign wr_ok   = push && (!full || rd_ok);
    assign rd_data = mem[rptr_q];
    assign level   = level_q;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            level_q <= '0;
            overrun <= 1'b0;
        end else begin
            if (wr_ok) wptr_q <= ptr_next(wptr_q);
            if (rd_ok) rptr_q <= ptr_next(rptr_q);
            if (wr_ok && !rd_ok)      level_q <= level_q + LVL_W'(1);
            else if (rd_ok && !wr_ok) level_q <= level_q - LVL_W'(1);
            if (push && !wr_ok)       overrun <= 1'b1;
            else if (stat_rd)         overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/irrx_carrier.sv
module irrx_carrier #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             rise,
    output logic [CNT_W-1:0] count,
    output logic             valid
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               count <= '0;
        else if (clr)                             count <= '0;
        else if (en && rise && count != CNT_TOP)  count <= count + CNT_W'(1);
    end

    assign valid = (count != '0) && (count != CNT_TOP);
endmodule

// File: rtl/irrx_sampler.sv
module irrx_sampler
    import irrx_pkg::*;
#(
    parameter int SLOW_DIV    = 1000,
    parameter int FAST_DIV    = 200,
    parameter int DEPTH       = 16,
    parameter int IRQ_THRESH  = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ir_in,
    input  logic                         oversample,
    input  logic                         invert,
    input  logic                         rx_disable,
    input  logic                         cnt_en,
    input  logic                         cnt_clr,
    input  logic                         rd_en,
    input  logic                         stat_rd,
    output logic [BYTE_W-1:0]            rd_data,
    output logic                         data_avail,
    output logic                         overrun,
    output logic [$clog2(DEPTH+1)-1:0]   fifo_level,
    output logic                         irq_rx,
    output logic [CNT_W-1:0]             carrier_count,
    output logic                         carrier_valid
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic              level, rise, tick;
    logic              push, full;
    logic [BYTE_W-1:0] push_byte;

    irrx_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .invert(invert),
        .level(level), .rise(rise)
    );

    irrx_tick #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .fast(oversample), .tick(tick)
    );

    irrx_runlen u_runlen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .level(level),
        .rx_disable(rx_disable), .fifo_full(full), .fifo_pop(rd_en),
        .push(push), .push_byte(push_byte)
    );

    irrx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_byte),
        .pop(rd_en), .stat_rd(stat_rd), .rd_data(rd_data), .full(full),
        .level(fifo_level), .overrun(overrun)
    );

    irrx_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .clr(cnt_clr), .rise(rise),
        .count(carrier_count), .valid(carrier_valid)
    );

    assign data_avail = (fifo_level != '0);
    assign irq_rx     = (fifo_level >= LVL_W'(IRQ_THRESH));
endmodule

// File: rtl/irrx_sampler_chk.sv
module irrx_sampler_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_disable,
    input logic             cnt_en,
    input logic             cnt_clr,
    input logic             stat_rd,
    input logic             data_avail,
    input logic             overrun,
    input logic [LVL_W-1:0] fifo_level,
    input logic [CNT_W-1:0] carrier_count
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH)); // R7

    AST_AVAIL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        data_avail == (fifo_level != '0)); // R7

    AST_OVERRUN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(fifo_level) == LVL_W'(DEPTH)); // R9

    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && fifo_level != LVL_W'(DEPTH)) |=> !overrun); // R10

    AST_DISABLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_disable |=> fifo_level <= $past(fifo_level)); // R5

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> carrier_count == '0); // R11

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_clr) |=> $stable(carrier_count)); // R11

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_count == '1 && !cnt_clr) |=> carrier_count == '1); // R12
endmodule

bind irrx_sampler irrx_sampler_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_disable(rx_disable), .cnt_en(cnt_en),
    .cnt_clr(cnt_clr), .stat_rd(stat_rd), .data_avail(data_avail),
    .overrun(overrun), .fifo_level(fifo_level), .carrier_count(carrier_count)
);

// File: tb/irrx_sampler_bench.sv
`timescale 1ns/1ps
module irrx_sampler_bench;
    localparam int SLOW  = 10;
    localparam int FAST  = 2;
    localparam int DEPTH = 16;
    localparam int CNT_W = 10;
    localparam int LVL_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_in = 1'b0, oversample = 1'b0, invert = 1'b0, rx_disable = 1'b0;
    logic cnt_en = 1'b0, cnt_clr = 1'b0, rd_en = 1'b0, stat_rd = 1'b0;
    logic [7:0]       rd_data;
    logic             data_avail, overrun, irq_rx, carrier_valid;
    logic [LVL_W-1:0] fifo_level;
    logic [CNT_W-1:0] carrier_count;

    int  nchk = 0, nerr = 0;
    bit  done = 1'b0;
    bit  inv = 1'b0;
    logic [7:0] exp_q [0:63];
    int  exp_n = 0;
    int  run_len [0:63];
    int  run_n = 0;

    always #5 clk = ~clk;

    irrx_sampler #(.SLOW_DIV(SLOW), .FAST_DIV(FAST), .DEPTH(DEPTH),
                   .IRQ_THRESH(8), .CNT_W(CNT_W)) u_irrx_sampler (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .oversample(oversample),
        .invert(invert), .rx_disable(rx_disable), .cnt_en(cnt_en),
        .cnt_clr(cnt_clr), .rd_en(rd_en), .stat_rd(stat_rd),
        .rd_data(rd_data), .data_avail(data_avail), .overrun(overrun),
        .fifo_level(fifo_level), .irq_rx(irq_rx),
        .carrier_count(carrier_count), .carrier_valid(carrier_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected bytes of one run (R1, R3)
    task automatic model_run(input bit sp, input int n);
        int rem = n;
        while (rem > 128) begin
            exp_q[exp_n] = {sp, 7'h7F};
            exp_n++;
            rem -= 128;
        end
        exp_q[exp_n] = {sp, 7'(rem - 1)};
        exp_n++;
    endtask

    task automatic clear_runs();
        run_n = 0;
        exp_n = 0;
    endtask

    // even index = pulse, odd index = space
    task automatic add_run(input int n);
        model_run(bit'(run_n % 2), n);
        run_len[run_n] = n;
        run_n++;
    endtask

    task automatic drive_runs(input int div);
        for (int i = 0; i < run_n; i++) begin
            ir_in = ((i % 2) == 0) ^ inv;
            repeat (run_len[i] * div) @(negedge clk);
        end
        ir_in = 1'b0 ^ inv;
        repeat (20 * div) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        chk({tag, " R7 level"}, 32'(fifo_level), 32'(exp_n));
        chk({tag, " R8 irq"}, 32'(irq_rx), 32'(exp_n >= 8));
        for (int i = 0; i < exp_n; i++) begin
            chk({tag, " R1 byte"}, 32'(rd_data), 32'(exp_q[i]));
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        chk({tag, " R7 empty"}, 32'(data_avail), 32'd0);
    endtask

    task automatic abort_rx();
        rx_disable = 1'b1;
        repeat (3) @(negedge clk);
        rx_disable = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_seq(input string tag, input int div);
        drive_runs(div);
        drain(tag);
        abort_rx();
    endtask

    task automatic toggle(input int k);
        repeat (k) begin
            ir_in = 1'b1;
            repeat (2) @(negedge clk);
            ir_in = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic random_seq(input string tag, input int div);
        clear_runs();
        forever begin
            add_run(int'($urandom_range(160, 1)));
            if (exp_n >= 10) break;
            add_run(int'($urandom_range(160, 1)));
        end
        run_seq(tag, div);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R13 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chk("R13 avail", 32'(data_avail), 0);
        chk("R13 level", 32'(fifo_level), 0);
        chk("R13 overrun", 32'(overrun), 0);
        chk("R13 irq", 32'(irq_rx), 0);
        chk("R13 count", 32'(carrier_count), 0);
        chk("R13 valid", 32'(carrier_valid), 0);

        // R1 basic
        clear_runs(); add_run(5); add_run(3); add_run(1);
        run_seq("R1 basic", SLOW);

        // R3 long runs split
        clear_runs(); add_run(128); add_run(129); add_run(256);
        run_seq("R3 split", SLOW);

        // R4 long idle space records nothing
        ir_in = 1'b0;
        repeat (300 * SLOW) @(negedge clk);
        chk("R4 idle level", 32'(fifo_level), 0);

        // R5 abort mid-pulse discards the run
        ir_in = 1'b1;
        repeat (30 * SLOW) @(negedge clk);
        rx_disable = 1'b1;
        ir_in = 1'b0;
        repeat (3) @(negedge clk);
        rx_disable = 1'b0;
        repeat (5 * SLOW) @(negedge clk);
        chk("R5 discard level", 32'(fifo_level), 0);
        clear_runs(); add_run(4);
        run_seq("R4 R5 restart", SLOW);

        // R9 overrun and error state
        clear_runs();
        for (int i = 0; i < 21; i++) add_run(2);
        drive_runs(SLOW);
        chk("R9 overrun set", 32'(overrun), 1);
        chk("R9 full level", 32'(fifo_level), DEPTH);
        chk("R8 irq full", 32'(irq_rx), 1);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R9 kept byte", 32'(rd_data), 32'(exp_q[i]));
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        clear_runs(); add_run(3); add_run(3); add_run(3);
        drive_runs(SLOW);
        chk("R9 error drops", 32'(fifo_level), 0);
        chk("R9 sticky", 32'(overrun), 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R10 cleared", 32'(overrun), 0);
        abort_rx();
        clear_runs(); add_run(2);
        run_seq("R9 recover", SLOW);

        // R2 fine sample period
        rx_disable = 1'b1;
        oversample = 1'b1;
        repeat (5) @(negedge clk);
        rx_disable = 1'b0;
        clear_runs(); add_run(7); add_run(130); add_run(2);
        run_seq("R2 fast", FAST);
        for (int b = 0; b < 3; b++) random_seq("R2 random fast", FAST);
        rx_disable = 1'b1;
        oversample = 1'b0;
        repeat (5) @(negedge clk);
        rx_disable = 1'b0;

        // R6 inverted input
        rx_disable = 1'b1;
        invert = 1'b1;
        inv = 1'b1;
        ir_in = 1'b1;
        repeat (5) @(negedge clk);
        rx_disable = 1'b0;
        clear_runs(); add_run(9); add_run(140); add_run(3);
        run_seq("R6 invert", SLOW);
        rx_disable = 1'b1;
        invert = 1'b0;
        inv = 1'b0;
        ir_in = 1'b0;
        repeat (5) @(negedge clk);
        rx_disable = 1'b0;

        // random coarse sequences
        for (int b = 0; b < 5; b++) random_seq("R1 random slow", SLOW);

        // R11 R12 carrier counter
        rx_disable = 1'b1;
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        chk("R11 clear", 32'(carrier_count), 0);
        chk("R12 zero invalid", 32'(carrier_valid), 0);
        cnt_en = 1'b1;
        toggle(37);
        chk("R11 count", 32'(carrier_count), 37);
        chk("R12 valid", 32'(carrier_valid), 1);
        cnt_en = 1'b0;
        toggle(10);
        chk("R11 hold", 32'(carrier_count), 37);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        chk("R11 clear again", 32'(carrier_count), 0);
        cnt_en = 1'b1;
        toggle(1100);
        chk("R12 saturate", 32'(carrier_count), (1 << CNT_W) - 1);
        chk("R12 top invalid", 32'(carrier_valid), 0);
        cnt_en = 1'b0;
        rx_disable = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule